// File: doc/BRIEF.md
# Lockable Fault-to-Break Routing Register

This block is one word-wide configuration register that steers three system fault indications onto a single timer break output. The three fault sources are a memory parity error pulse, a processor lockup (hard-fault) indication and a supply-voltage-monitor interrupt. Each source has its own route-enable bit. Software can set a route-enable bit but cannot clear it. Only a synchronous system reset clears it, so once a fault path is armed, errant code cannot disarm it.

The register also holds a parity error flag. Hardware sets this flag and software clears it by writing one to it. A further output reports that the voltage-monitor route is locked. A neighbouring power-control model uses that output to freeze its monitor-enable bit and its three-bit threshold field. The register sits on a plain bus with write enable, address, write data and registered read data.

Top module: `fault_break_router`

## Requirements
- R1: After a synchronous reset, all three route-enable bits read 0, the parity flag reads 0, and `brk_o`, `cfg_locked` and `reg_rdata` are all 0.
- R2: A write to the register address with a 1 in a route-enable position sets that bit. A 0 in that position leaves the bit unchanged. Once set, a route-enable bit stays 1 until reset.
- R3: The route-enable bit positions are: bit 0 for the lockup source `lockup_i`, bit 1 for the parity source `parity_err_i`, and bit 2 for the voltage-monitor source `vmon_irq_i`.
- R4: `brk_o` is a register. One clock edge after the inputs are sampled, it equals the OR of each source ANDed with its own route-enable bit. A source whose route-enable bit is 0 cannot raise `brk_o`.
- R5: The parity flag is at bit 8. It becomes 1 on the clock edge after `parity_err_i` is seen high, whatever the value of the parity route-enable bit.
- R6: Writing 1 to bit 8 clears the parity flag. Writing 0 to bit 8 leaves it unchanged. If a parity error and a clearing write arrive in the same cycle, the flag stays 1.
- R7: `cfg_locked` is 1 exactly when the voltage-monitor route-enable bit (bit 2) is 1.
- R8: `reg_rdata` is registered. One edge after an address is presented, it returns bits 2:0 = route enables and bit 8 = parity flag at the register address, with all other bits 0. Any other address reads as all zeros.
- R9: Writes to any address other than the register address change nothing. Writes to bits 31:9 and 7:3 have no effect, and those bits always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | ADDR_W (4) | Word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| lockup_i | input | 1 | Processor lockup indication |
| parity_err_i | input | 1 | Memory parity error pulse |
| vmon_irq_i | input | 1 | Voltage-monitor interrupt |
| brk_o | output | 1 | Registered timer break request |
| cfg_locked | output | 1 | Voltage-monitor configuration freeze |

## Verification
The bench builds the block with its default parameters: a 32-bit data bus, a 4-bit address and the register placed at address 0. With these values the bench can drive a write or read to a nonzero address, which shows that the decode ignores writes elsewhere and reads zeros there. The full 32-bit width lets it drive ones into every reserved bit. The bench also drives the same-cycle race between a parity error and a clearing write, and it checks every source against both states of its route-enable bit.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned LOCKUP_B = 0;
  localparam int unsigned PARITY_B = 1;
  localparam int unsigned VMON_B   = 2;
  localparam int unsigned FLAG_B   = 8;
endpackage

// File: rtl/fbr_lock_bits.sv
module fbr_lock_bits #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [N-1:0] set_bits,
  output logic [N-1:0] lock_q
);
  for (genvar i = 0; i < N; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                       lock_q[i] <= 1'b0;
      else if (wr_hit && set_bits[i]) lock_q[i] <= 1'b1;
    end

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> lock_q[i]);
    assert_lock_set_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && set_bits[i]) |=> lock_q[i]);
  end
endmodule

// File: rtl/fbr_parity_flag.sv
module fbr_parity_flag (
  input  logic clk,
  input  logic rst,
  input  logic err_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (err_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    err_i |=> flag_q);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !err_i) |=> !flag_q);
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !err_i) |=> $stable(flag_q));
endmodule

// File: rtl/fbr_break_gate.sv
module fbr_break_gate #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         brk_q
);
  logic any_live;
  assign any_live = |(src_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= any_live;
  end

  assert_break_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    ((src_i & en_i) == '0) |=> !brk_q);
  assert_break_raised_R4: assert property (@(posedge clk) disable iff (rst)
    ((src_i & en_i) != '0) |=> brk_q);
endmodule

// File: rtl/fault_break_router.sv
module fault_break_router
  import fbr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              lockup_i,
  input  logic              parity_err_i,
  input  logic              vmon_irq_i,
  output logic              brk_o,
  output logic              cfg_locked
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);
  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(1) << FLAG_B) | DATA_W'((1 << NUM_SRC) - 1);
  localparam logic [DATA_W-1:0] RSVD_MASK = ~LIVE_MASK;

  logic               wr_hit;
  logic               rd_hit;
  logic [NUM_SRC-1:0] lock_q;
  logic [NUM_SRC-1:0] src_vec;
  logic               flag_q;
  logic [DATA_W-1:0]  image;

  assign rd_hit = (reg_addr == SEL);
  assign wr_hit = reg_we && rd_hit;

  assign src_vec[LOCKUP_B] = lockup_i;
  assign src_vec[PARITY_B] = parity_err_i;
  assign src_vec[VMON_B]   = vmon_irq_i;

  fbr_lock_bits #(.N(NUM_SRC)) u_locks (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .set_bits (reg_wdata[NUM_SRC-1:0]),
    .lock_q   (lock_q)
  );

  fbr_parity_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .err_i  (parity_err_i),
    .clr_i  (wr_hit && reg_wdata[FLAG_B]),
    .flag_q (flag_q)
  );

  fbr_break_gate #(.N(NUM_SRC)) u_brk (
    .clk   (clk),
    .rst   (rst),
    .src_i (src_vec),
    .en_i  (lock_q),
    .brk_q (brk_o)
  );

  always_comb begin
    image = '0;
    image[NUM_SRC-1:0] = lock_q;
    image[FLAG_B] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_hit) reg_rdata <= image;
    else             reg_rdata <= '0;
  end

  assign cfg_locked = lock_q[VMON_B];

  assert_cfg_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> cfg_locked);
  assert_other_addr_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (reg_rdata == '0));
  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && ((reg_wdata & RSVD_MASK) != '0)) |=> ##1 ((reg_rdata & RSVD_MASK) == '0));
  assert_other_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !rd_hit && !parity_err_i) |=> ($stable(lock_q) && $stable(flag_q)));
endmodule

// File: tb/fault_break_router_tb_top.sv
module fault_break_router_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lockup_i = 1'b0, parity_err_i = 1'b0, vmon_irq_i = 1'b0;
  logic        brk_o, cfg_locked;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_break_router dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lockup_i(lockup_i),
    .parity_err_i(parity_err_i), .vmon_irq_i(vmon_irq_i),
    .brk_o(brk_o), .cfg_locked(cfg_locked)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0; reg_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 brk", {31'b0, brk_o}, 0);
    chk("R1 cfg_locked", {31'b0, cfg_locked}, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(4'd0, d);
    chk("R1 register", d, 0);
  endtask

  task automatic t_locks();
    logic [31:0] d;
    wr(4'd0, 32'h0000_0001);
    rd(4'd0, d);
    chk("R2 set lockup lock", d, 32'h1);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d);
    chk("R2 write 0 keeps lock", d, 32'h1);
    chk("R7 cfg_locked low", {31'b0, cfg_locked}, 0);
    wr(4'd0, 32'h0000_0004);
    chk("R7 cfg_locked high", {31'b0, cfg_locked}, 1);
    rd(4'd0, d);
    chk("R2 accumulate", d, 32'h5);
  endtask

  task automatic t_break_gating();
    // lockup (bit0) and vmon (bit2) enabled, parity route (bit1) disabled
    lockup_i = 1'b1; tick(); lockup_i = 1'b0;
    chk("R3 R4 lockup routes", {31'b0, brk_o}, 1);
    tick();
    chk("R4 break falls", {31'b0, brk_o}, 0);
    vmon_irq_i = 1'b1; tick(); vmon_irq_i = 1'b0;
    chk("R3 R4 vmon routes", {31'b0, brk_o}, 1);
    tick();
    parity_err_i = 1'b1; tick(); parity_err_i = 1'b0;
    chk("R4 parity blocked", {31'b0, brk_o}, 0);
  endtask

  task automatic t_flag();
    logic [31:0] d;
    rd(4'd0, d);
    chk("R5 flag set without route", d, 32'h105);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d);
    chk("R6 write 0 keeps flag", d, 32'h105);
    wr(4'd0, 32'h0000_0100);
    rd(4'd0, d);
    chk("R6 w1c clears flag", d, 32'h5);
    parity_err_i = 1'b1;
    wr(4'd0, 32'h0000_0100);
    parity_err_i = 1'b0;
    rd(4'd0, d);
    chk("R6 set beats clear", d, 32'h105);
    wr(4'd0, 32'h0000_0102);
    parity_err_i = 1'b1; tick(); parity_err_i = 1'b0;
    chk("R3 R4 parity routes", {31'b0, brk_o}, 1);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    do_reset();
    wr(4'd3, 32'hFFFF_FFFF);
    chk("R9 other addr write ignored cfg", {31'b0, cfg_locked}, 0);
    rd(4'd0, d);
    chk("R9 other addr write ignored", d, 0);
    wr(4'd0, 32'hFFFF_FEF8);
    rd(4'd0, d);
    chk("R9 reserved bits ignored", d, 0);
    wr(4'd0, 32'h0000_0007);
    rd(4'd5, d);
    chk("R8 other addr reads zero", d, 0);
    rd(4'd0, d);
    chk("R8 read image", d, 32'h7);
    do_reset();
    rd(4'd0, d);
    chk("R1 R2 reset clears locks", d, 0);
    chk("R1 R7 reset clears cfg_locked", {31'b0, cfg_locked}, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_locks();
    t_break_gating();
    t_flag();
    t_decode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule